// File: doc/BRIEF.md
# Master-Mode Audio Serial Transmitter

This block turns a stream of audio words into a two-slot serial audio frame. It generates the bit clock and the frame sync from the system clock, pulls one word per slot from an upstream FIFO over a valid/ready handshake, and shifts each word out most significant bit first on the serial data line. The frame is generated only while the block is enabled.

A small set of static configuration inputs controls the stream. They select the slot width (8, 16, 24 or 32 bits), stereo or mono handling, and either standard I2S timing or MSB-justified timing. They also set a mute, which sends zeros, and an 8-bit bit-clock divider. Status outputs report which channel is being driven, whether transmit data is in flight, and a sticky underflow flag that is cleared by a write-one pulse. The configuration must be held stable while the block is enabled.

Top module: `i2s_tx_master`

## Requirements
- R1: While enabled (`cfg_enable` and `cfg_tx_en` both 1), `bclk` has a period of 2×(`cfg_bclk_div`+1) system clocks, with equal high and low halves.
- R2: `cfg_width` code 0/1/2/3 gives a slot length of 8/16/24/32 bit clocks. Each frame has two slots, left then right, and the slots follow each other with no gap.
- R3: Each slot carries the low W bits of its word (W = slot length), most significant first. `sd` changes only when `bclk` falls and is stable while `bclk` is high.
- R4: `fs` is low for the left slot and high for the right slot. With `cfg_msbj`=1 it changes on the same falling edge as the first bit of a slot. With `cfg_msbj`=0 it changes one bit clock earlier.
- R5: In stereo (`cfg_mono`=0) one word is pulled per slot, taken alternately for left and right. In mono (`cfg_mono`=1) one word is pulled per frame and sent in both slots.
- R6: While `cfg_mute`=1 no word is pulled, every slot carries zeros, and underflow is not raised.
- R7: `right_active` is 1 exactly while the bit on `sd` belongs to the right slot.
- R8: A pull made while `word_valid`=0 sends a zero slot and sets `underflow`. The flag stays set until a cycle with `udf_clr`=1, and setting takes priority over clearing.
- R9: `busy` goes to 1 when a FIFO word is loaded into the shifter. It goes to 0 at a slot start where no word is taken (empty FIFO or mute), and it is 0 while the block is disabled.
- R10: While disabled, `bclk`, `fs`, `sd`, `right_active` and `busy` are held low, and the next enable starts a new frame at the left slot.
- R11: After reset, all outputs are low.
- R12: `word_ready` is 1 only in the system clock cycle in which `bclk` falls at the start of a slot that needs a new word. A transfer happens when `word_ready` and `word_valid` are both 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable |
| cfg_tx_en | input | 1 | Transmit enable; the block runs only when both enables are 1 |
| cfg_mute | input | 1 | 1: send zeros and pull no words |
| cfg_width | input | 2 | Slot width code: 0=8, 1=16, 2=24, 3=32 bits |
| cfg_mono | input | 1 | 1: one word per frame, sent in both slots |
| cfg_msbj | input | 1 | 0: standard I2S timing, 1: MSB-justified timing |
| cfg_bclk_div | input | DIV_W | Bit clock divider value D; the period is 2×(D+1) clocks |
| udf_clr | input | 1 | Write-one clear for the underflow flag |
| word_valid | input | 1 | The FIFO has a word available |
| word_data | input | WORD_W | FIFO word, right-justified |
| word_ready | output | 1 | Pull strobe to the FIFO |
| bclk | output | 1 | Bit clock |
| fs | output | 1 | Frame sync: 0 = left slot, 1 = right slot |
| sd | output | 1 | Serial data |
| right_active | output | 1 | The current `sd` bit belongs to the right slot |
| busy | output | 1 | Transmit data is in flight |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The hardest situation to reach is the boundary where live FIFO data runs out in the middle of a frame. At that point the next slot must go to zeros, `busy` must drop on that exact slot start, and `underflow` must latch. In standard I2S mode the last bit of the previous right word also spills past the frame sync edge at that boundary. The bench reaches this case by handing the model FIFO a short, finite word list in every run and then clocking well past its end. Widths, mono/stereo, framing and divider values are randomized with a fixed seed. Directed runs add mute, the largest practical divider and a single-word list.

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_tx_en,
  input  logic              cfg_mute,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_mono,
  input  logic              cfg_msbj,
  input  logic [DIV_W-1:0]  cfg_bclk_div,
  input  logic              udf_clr,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              bclk,
  output logic              fs,
  output logic              sd,
  output logic              right_active,
  output logic              busy,
  output logic              underflow
);
  localparam int CNT_W = $clog2(2 * WORD_W) + 1;

  logic [DIV_W-1:0]  div_cnt;
  logic              bclk_q, started, fs_q, right_q, busy_q, udf_q;
  logic [CNT_W-1:0]  dk;
  logic [WORD_W-1:0] sh, mono_hold;

  logic              active, fall_tick, in_right, slot_start, reuse, pull, taken;
  logic [CNT_W-1:0]  slot_len, frame_len, nk, nk1, sh_amt;
  logic [WORD_W-1:0] load_val;

  assign active    = cfg_enable & cfg_tx_en;
  assign fall_tick = active & bclk_q & (div_cnt == cfg_bclk_div);
  assign slot_len  = CNT_W'({cfg_width, 3'b000}) + CNT_W'(8);
  assign frame_len = slot_len << 1;
  assign sh_amt    = CNT_W'(WORD_W) - slot_len;

  always_comb begin
    if (!started || (dk + CNT_W'(1) >= frame_len)) nk = '0;
    else nk = dk + CNT_W'(1);
    if (nk + CNT_W'(1) >= frame_len) nk1 = '0;
    else nk1 = nk + CNT_W'(1);
  end

  assign in_right   = (nk >= slot_len);
  assign slot_start = (nk == '0) || (nk == slot_len);
  assign reuse      = cfg_mono & in_right;
  assign pull       = fall_tick & slot_start & ~cfg_mute & ~reuse;
  assign taken      = pull & word_valid;

  always_comb begin
    if (cfg_mute)   load_val = '0;
    else if (reuse) load_val = mono_hold;
    else if (taken) load_val = word_data << sh_amt;
    else            load_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      bclk_q    <= 1'b0;
      started   <= 1'b0;
      dk        <= '0;
      sh        <= '0;
      mono_hold <= '0;
      fs_q      <= 1'b0;
      right_q   <= 1'b0;
      busy_q    <= 1'b0;
      udf_q     <= 1'b0;
    end else if (!active) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
      started <= 1'b0;
      dk      <= '0;
      sh      <= '0;
      fs_q    <= 1'b0;
      right_q <= 1'b0;
      busy_q  <= 1'b0;
      if (udf_clr) udf_q <= 1'b0;
    end else begin
      if (div_cnt == cfg_bclk_div) begin
        div_cnt <= '0;
        bclk_q  <= ~bclk_q;
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
      if (fall_tick) begin
        started <= 1'b1;
        dk      <= nk;
        right_q <= in_right;
        fs_q    <= cfg_msbj ? in_right : (nk1 >= slot_len);
        if (slot_start) sh <= load_val;
        else            sh <= sh << 1;
        if (slot_start && !reuse) begin
          mono_hold <= load_val;
          busy_q    <= taken;
        end
      end
      if (pull && !word_valid) udf_q <= 1'b1;
      else if (udf_clr)        udf_q <= 1'b0;
    end
  end

  assign word_ready   = pull;
  assign bclk         = bclk_q;
  assign fs           = fs_q;
  assign sd           = sh[WORD_W-1];
  assign right_active = right_q;
  assign busy         = busy_q;
  assign underflow    = udf_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!bclk && !fs && !sd && !busy && !right_active)); // R10
  AST_PULL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |=> $fell(bclk)); // R12
  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(sd)) |-> $fell(bclk)); // R3
  AST_FS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(fs)) |-> $fell(bclk)); // R4
  AST_MUTE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mute |-> !word_ready); // R6
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !udf_clr) |=> underflow); // R8
endmodule

// File: tb/sim_i2s_tx_master.sv
module sim_i2s_tx_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_tx_en = 1'b0, cfg_mute = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic        cfg_mono = 1'b0, cfg_msbj = 1'b0;
  logic [7:0]  cfg_bclk_div = 8'd0;
  logic        udf_clr = 1'b0;
  logic        word_valid;
  logic [31:0] word_data;
  logic        word_ready, bclk, fs, sd, right_active, busy, underflow;

  logic [31:0] qmem [0:15];
  logic [4:0]  qh;
  logic [4:0]  qn = 5'd0;
  logic        q_clear = 1'b0;
  int          checks = 0, errors = 0;
  int          cyc = 0;

  always #10 clk = ~clk;

  i2s_tx_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_tx_en(cfg_tx_en),
    .cfg_mute(cfg_mute), .cfg_width(cfg_width), .cfg_mono(cfg_mono),
    .cfg_msbj(cfg_msbj), .cfg_bclk_div(cfg_bclk_div), .udf_clr(udf_clr),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .bclk(bclk), .fs(fs), .sd(sd), .right_active(right_active),
    .busy(busy), .underflow(underflow)
  );

  assign word_valid = (qh < qn);
  assign word_data  = qmem[qh[3:0]];

  always_ff @(posedge clk) begin
    if (q_clear) qh <= 5'd0;
    else if (word_ready && word_valid) qh <= qh + 5'd1;
  end

  always @(negedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(int k, int w, bit mono, bit mute, int n);
    int s, b, wi;
    logic [31:0] word;
    s = k / w; b = k % w;
    wi = mono ? s / 2 : s;
    if (mute || wi >= n) word = 32'd0;
    else word = qmem[wi];
    return word[w-1-b];
  endfunction

  function automatic bit exp_fs(int k, int w, bit msbj);
    if (msbj) return (k % (2*w)) >= w;
    return ((k + 1) % (2*w)) >= w;
  endfunction

  task automatic run(input int wc, input bit mono, input bit msbj, input bit mute,
                     input int div, input int n);
    int w, slots, total, j, last_rise, guard;
    bit prevb, sd_bad, fs_bad, rt_bad;
    w = 8 * (wc + 1);
    slots = mono ? 2 * (n + 1) : n + 2;
    total = 1 + slots * w;
    @(negedge clk);
    cfg_enable = 1'b0; cfg_tx_en = 1'b0; udf_clr = 1'b1; q_clear = 1'b1;
    for (int i = 0; i < 16; i++) qmem[i] = $urandom;
    qn = 5'(n);
    cfg_width = 2'(wc); cfg_mono = mono; cfg_msbj = msbj; cfg_mute = mute;
    cfg_bclk_div = 8'(div);
    @(negedge clk);
    udf_clr = 1'b0; q_clear = 1'b0;
    @(negedge clk);
    cfg_enable = 1'b1; cfg_tx_en = 1'b1;
    prevb = 1'b0; j = 0; last_rise = 0; guard = 0;
    sd_bad = 0; fs_bad = 0; rt_bad = 0;
    while (j < total && guard < 60000) begin
      @(negedge clk);
      guard++;
      if (bclk && !prevb) begin
        if (j == 2) chk((cyc - last_rise) == 2 * (div + 1), "R1", "bclk period",
                        cyc - last_rise, 2 * (div + 1));
        last_rise = cyc;
        if (j >= 1) begin
          int k = j - 1;
          if (!sd_bad && sd !== exp_bit(k, w, mono, mute, n)) begin
            sd_bad = 1;
            chk(0, "R3", $sformatf("sd bit %0d", k), sd, exp_bit(k, w, mono, mute, n));
          end
          if (!fs_bad && fs !== exp_fs(k, w, msbj)) begin
            fs_bad = 1;
            chk(0, "R4", $sformatf("fs bit %0d", k), fs, exp_fs(k, w, msbj));
          end
          if (!rt_bad && right_active !== ((k % (2*w)) >= w)) begin
            rt_bad = 1;
            chk(0, "R7", $sformatf("right_active bit %0d", k), right_active, (k % (2*w)) >= w);
          end
          if (j == w + 1 && !mute && (mono ? n >= 1 : n >= 2))
            chk(busy === 1'b1, "R9", "busy while streaming", busy, 1);
        end
        j++;
      end
      prevb = bclk;
    end
    if (!sd_bad) chk(1, "R2 R5", "stream", 0, 0);
    if (!fs_bad) chk(1, "R4", "fs", 0, 0);
    if (!rt_bad) chk(1, "R7", "right_active", 0, 0);
    chk(j == total, "R1", "bit clock ran", j, total);
    chk(busy === 1'b0, "R9", "busy after drain", busy, 0);
    chk(underflow === !mute, "R8", "underflow flag", underflow, !mute);
    chk(int'(qh) == (mute ? 0 : n), "R6", "words pulled", qh, mute ? 0 : n);
    @(negedge clk);
    cfg_tx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({bclk, fs, sd, right_active, busy} === 5'd0, "R10", "disabled outputs",
        {bclk, fs, sd, right_active, busy}, 0);
    if (!mute) chk(underflow === 1'b1, "R8", "flag sticky while disabled", underflow, 1);
    udf_clr = 1'b1;
    @(negedge clk);
    udf_clr = 1'b0;
    chk(underflow === 1'b0, "R8", "flag cleared", underflow, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({word_ready, bclk, fs, sd, right_active, busy, underflow} === 7'd0, "R11",
        "reset outputs", {word_ready, bclk, fs, sd, right_active, busy, underflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bclk, fs, sd} === 3'd0, "R11", "idle after reset", {bclk, fs, sd}, 0);
    run(3, 0, 0, 0, 0, 4);
    run(0, 1, 1, 0, 2, 3);
    run(1, 0, 1, 1, 1, 3);
    run(0, 0, 0, 0, 200, 1);
    run(2, 1, 0, 0, 1, 2);
    for (int t = 0; t < 10; t++)
      run(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'(($urandom % 5) == 0),
          int'($urandom % 4), 1 + int'($urandom % 4));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule